// File: doc/BRIEF.md
# Bus Write-Match Test Target

This block is a byte-wide register target a host uses to prove that its write paths reach a device. It has a memory window and an I/O window. Both share one access port that carries address, write data, write strobe, read strobe and access size, and a window-select bit tells them apart. A write of a mode number to address 0 picks one of six test contexts. The context index is the window type times three plus the mode.

While a context is active, it counts host writes that land on its own trigger address. In match mode a write counts only when its size and data byte are also correct. The host reads results back through a byte-addressable header. The header holds the context index, the access width, the trigger address, the expected data byte, the 32-bit hit counter and a short zero-terminated name. In the two notifying modes, every counted write raises a one-cycle pulse and sets a sticky pending flag.

Top module: `wrmatch_target`

## Requirements
- R1: After reset no context is active, `notify` and `note_pend` are low, and any read returns 0x00.
- R2: A write of value v to address 0 first deactivates the current context. If v < 3, context `win_io*3 + v` becomes active and its counter is set to zero. If v >= 3, no context is active afterwards.
- R3: Header bytes of context i are as follows. Byte 0 = i. Byte 1 = 1. Bytes 4..7 = trigger address, least significant byte first. Byte 8 = expected data (0xFA in mode 2, 0xCE otherwise). Bytes 12..15 = hit counter, least significant byte first. Bytes 2, 3 and 9..11 = 0. From byte 16 come the ASCII name and then a zero byte. The names for i = 0..5 are "mem-plain", "mem-any", "mem-match", "io-plain", "io-any" and "io-match".
- R4: The trigger address of context i is 2048+i for i < 3 and 128+i for i >= 3. It is compared against the address of a write in either window.
- R5: In modes 0 and 1, a write to the active trigger address adds one to the counter, whatever its data or size. The counter wraps modulo 2^32.
- R6: In mode 2, a trigger write counts only if its access size is 1 and its data is 0xFA.
- R7: Writes to any other address leave the counter unchanged, and a write to address 0 never counts as a hit.
- R8: A read returns 0x00 when address + size >= 17 + name length.
- R9: In modes 1 and 2, `notify` is high for exactly the cycle after each counted write, and `note_pend` rises with it. `note_pend` clears after an in-range read of the active context, unless a new hit arrives in the same cycle.
- R10: `rd_data` is registered. It changes only in the cycle after `rd_en` and holds otherwise. A counter change from a write is seen by a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_io | input | 1 | Window of the access: 0 memory, 1 I/O |
| addr | input | ADDR_W | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| acc_size | input | 3 | Access size in bytes |
| rd_data | output | 8 | Registered read data |
| notify | output | 1 | One-cycle pulse per counted write in modes 1 and 2 |
| note_pend | output | 1 | Sticky notify-pending flag |

## Verification
The effect of a write on the context and the counter lands on the next rising edge, so a read strobed in the following cycle already sees it. `rd_data`, `notify` and `note_pend` are all updated on the edge that samples the strobe, which makes each of them due one cycle after its cause. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. At every falling edge it compares all three outputs with the model, so each result is checked in exactly the cycle it is due and in the cycles where it must hold.

// File: rtl/wmt_pkg.sv
package wmt_pkg;
  localparam int CTX_N      = 6;
  localparam int MODE_N     = 3;
  localparam int CTX_W      = $clog2(CTX_N);
  localparam int CNT_W      = 32;
  localparam int MEM_WIN    = 2048;
  localparam int IO_WIN     = 128;
  localparam int HDR_FIXED  = 16;
  localparam int NAME_MAX   = 10;
  localparam logic [7:0] DATA_MATCH = 8'hFA;
  localparam logic [7:0] DATA_ANY   = 8'hCE;

  function automatic logic [1:0] mode_of(input logic [CTX_W-1:0] c);
    return (c >= CTX_W'(MODE_N)) ? 2'(c - CTX_W'(MODE_N)) : 2'(c);
  endfunction

  function automatic logic [15:0] trig_of(input logic [CTX_W-1:0] c);
    return (c < CTX_W'(MODE_N)) ? 16'(MEM_WIN) + 16'(c) : 16'(IO_WIN) + 16'(c);
  endfunction

  function automatic logic [4:0] name_len(input logic [CTX_W-1:0] c);
    case (c)
      3'd0: return 5'd9;
      3'd1: return 5'd7;
      3'd2: return 5'd9;
      3'd3: return 5'd8;
      3'd4: return 5'd6;
      default: return 5'd8;
    endcase
  endfunction

  function automatic logic [7:0] name_byte(input logic [CTX_W-1:0] c, input logic [4:0] k);
    logic [8*NAME_MAX-1:0] s;
    logic [4:0] n;
    case (c)
      3'd0: s = (8*NAME_MAX)'("mem-plain");
      3'd1: s = (8*NAME_MAX)'("mem-any");
      3'd2: s = (8*NAME_MAX)'("mem-match");
      3'd3: s = (8*NAME_MAX)'("io-plain");
      3'd4: s = (8*NAME_MAX)'("io-any");
      default: s = (8*NAME_MAX)'("io-match");
    endcase
    n = name_len(c);
    if (k >= n) return 8'h00;
    return s[8*(n-5'd1-k) +: 8];
  endfunction
endpackage

// File: rtl/wmt_sel.sv
module wmt_sel
  import wmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        acc_size,
  output logic              act,
  output logic [CTX_W-1:0]  ctx,
  output logic [CNT_W-1:0]  cnt,
  output logic              hit
);
  logic             act_q, act_d;
  logic [CTX_W-1:0] ctx_q, ctx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             data_ok;

  always_comb begin
    data_ok = (mode_of(ctx_q) != 2'd2) ||
              ((acc_size == 3'd1) && (wr_data == DATA_MATCH));
    act_d = act_q;
    ctx_d = ctx_q;
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (addr == '0) begin
      if (wr_data < 8'(MODE_N)) begin
        act_d = 1'b1;
        ctx_d = win_io ? CTX_W'(MODE_N) + CTX_W'(wr_data) : CTX_W'(wr_data);
        cnt_d = '0;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q && (addr == ADDR_W'(trig_of(ctx_q))) && data_ok) begin
      hit   = wr_en;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ctx_q <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      act_q <= act_d;
      ctx_q <= ctx_d;
      cnt_q <= cnt_d;
    end
  end

  assign act = act_q;
  assign ctx = ctx_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/wmt_hdr.sv
module wmt_hdr
  import wmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [CTX_W-1:0]  ctx,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        acc_size,
  output logic [7:0]        hbyte,
  output logic              in_rng
);
  localparam int SUM_W = ADDR_W + 1;
  logic [15:0]      trig;
  logic [SUM_W-1:0] end_a, hlen;
  logic [4:0]       nidx;

  always_comb begin
    trig   = trig_of(ctx);
    hlen   = SUM_W'(HDR_FIXED + 1) + SUM_W'(name_len(ctx));
    end_a  = SUM_W'(addr) + SUM_W'(acc_size);
    in_rng = end_a < hlen;
    nidx   = 5'(addr - ADDR_W'(HDR_FIXED));
    hbyte  = 8'h00;
    if (addr >= ADDR_W'(HDR_FIXED)) begin
      hbyte = name_byte(ctx, nidx);
    end else begin
      case (addr[3:0])
        4'd0:  hbyte = 8'(ctx);
        4'd1:  hbyte = 8'd1;
        4'd4:  hbyte = trig[7:0];
        4'd5:  hbyte = trig[15:8];
        4'd8:  hbyte = (mode_of(ctx) == 2'd2) ? DATA_MATCH : DATA_ANY;
        4'd12: hbyte = cnt[7:0];
        4'd13: hbyte = cnt[15:8];
        4'd14: hbyte = cnt[23:16];
        4'd15: hbyte = cnt[31:24];
        default: hbyte = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/wrmatch_target.sv
module wrmatch_target
  import wmt_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [2:0]        acc_size,
  output logic [7:0]        rd_data,
  output logic              notify,
  output logic              note_pend
);
  logic             act, hit, in_rng;
  logic [CTX_W-1:0] ctx;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       hbyte;
  logic [7:0]       rd_q, rd_d;
  logic             note_q, note_d, pend_q, pend_d, clr;

  wmt_sel #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .win_io(win_io), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .acc_size(acc_size), .act(act), .ctx(ctx), .cnt(cnt),
    .hit(hit)
  );

  wmt_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .ctx(ctx), .cnt(cnt), .addr(addr), .acc_size(acc_size),
    .hbyte(hbyte), .in_rng(in_rng)
  );

  always_comb begin
    rd_d   = (act && in_rng) ? hbyte : 8'h00;
    clr    = rd_en && act && in_rng && (mode_of(ctx) != 2'd0);
    note_d = hit && (mode_of(ctx) != 2'd0);
    pend_d = note_d || (pend_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 8'h00;
      note_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_d;
      note_q <= note_d;
      pend_q <= pend_d;
    end
  end

  assign rd_data   = rd_q;
  assign notify    = note_q;
  assign note_pend = pend_q;
endmodule

// File: rtl/wmt_chk.sv
module wmt_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              notify,
  input logic              note_pend,
  input logic              act,
  input logic [31:0]       cnt
);
  AST_SEL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> (act == $past(wr_data < 8'd3))); // R2
  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0 && wr_data < 8'd3) |=> (cnt == 32'd0)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cnt)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && wr_en && addr != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 32'd1)); // R5
  AST_NOTE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> $past(wr_en)); // R9
  AST_NOTE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> note_pend); // R9
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !act) |=> (rd_data == 8'h00)); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R10
endmodule

bind wrmatch_target wmt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .notify(notify), .note_pend(note_pend),
  .act(act), .cnt(cnt)
);

// File: tb/wrmatch_target_bench.sv
module wrmatch_target_bench;
  localparam int AW = 12;
  logic clk, rst_n, win_io, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [7:0] wr_data, rd_data;
  logic [2:0] acc_size;
  logic notify, note_pend;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";

  wrmatch_target #(.ADDR_W(AW)) u_wrmatch_target (
    .clk(clk), .rst_n(rst_n), .win_io(win_io), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .acc_size(acc_size), .rd_data(rd_data),
    .notify(notify), .note_pend(note_pend)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model
  string names [6] = '{"mem-plain", "mem-any", "mem-match", "io-plain", "io-any", "io-match"};
  bit m_act; int m_ctx; longint m_cnt; int e_rd; bit e_note, e_pend;

  function automatic int trig(int c);
    return (c < 3) ? 2048 + c : 128 + c;
  endfunction
  function automatic int hdr(int c, int a, longint n);
    int t = trig(c);
    if (a == 0) return c;
    if (a == 1) return 1;
    if (a >= 4 && a <= 7) return (t >> (8*(a-4))) & 255;
    if (a == 8) return (c % 3 == 2) ? 'hFA : 'hCE;
    if (a >= 12 && a <= 15) return int'((n >> (8*(a-12))) & 255);
    if (a >= 16 && a - 16 < names[c].len()) return names[c][a-16];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ctx = 0; m_cnt = 0; e_rd = 0; e_note = 0; e_pend = 0;
    end else begin
      bit inr, clr, cnted;
      inr = m_act && (int'(addr) + int'(acc_size) < 17 + names[m_ctx].len());
      clr = rd_en && inr && (m_ctx % 3 != 0);
      if (rd_en) e_rd = inr ? hdr(m_ctx, int'(addr), m_cnt) : 0;
      cnted = 0;
      if (wr_en) begin
        if (addr == 0) begin
          m_act = 0;
          if (wr_data < 3) begin m_act = 1; m_ctx = 3*int'(win_io) + int'(wr_data); m_cnt = 0; end
        end else if (m_act && int'(addr) == trig(m_ctx)) begin
          if (m_ctx % 3 != 2 || (acc_size == 1 && wr_data == 8'hFA)) begin
            cnted = 1; m_cnt = (m_cnt + 1) % (64'd1 << 32);
          end
        end
      end
      e_note = cnted && (m_ctx % 3 != 0);
      e_pend = e_note || (e_pend && !clr);
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (rd_data !== 8'(e_rd) || notify !== e_note || note_pend !== e_pend) begin
      errors++;
      $display("FAIL %s: rd_data=%02h notify=%b pend=%b expected rd_data=%02h notify=%b pend=%b",
               tag, rd_data, notify, note_pend, 8'(e_rd), e_note, e_pend);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    wr_en = 0; rd_en = 0; addr = '0; wr_data = 0; acc_size = 3'd1;
    @(negedge clk);
  endtask
  task automatic wr(input bit w, input int a, input int d, input int s);
    win_io = w; addr = AW'(a); wr_data = 8'(d); acc_size = 3'(s); wr_en = 1; rd_en = 0;
    @(negedge clk);
    wr_en = 0;
  endtask
  task automatic rd(input bit w, input int a, input int s);
    win_io = w; addr = AW'(a); acc_size = 3'(s); rd_en = 1; wr_en = 0;
    @(negedge clk);
    rd_en = 0;
  endtask
  task automatic dump(input bit w, input int len);
    for (int a = 0; a < len; a++) rd(w, a, 1);
  endtask

  initial begin
    rst_n = 0; win_io = 0; wr_en = 0; rd_en = 0; addr = '0; wr_data = 0; acc_size = 3'd1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; idle(); rd(0, 0, 1); rd(1, 4, 1); idle();
    tag = "R2"; wr(0, 0, 5, 1); rd(0, 0, 1); wr(0, 0, 0, 1); rd(0, 0, 1); idle();
    tag = "R3"; dump(0, 28);
    tag = "R8"; rd(0, 24, 1); rd(0, 25, 1); rd(0, 23, 2); rd(0, 24, 2); idle();
    tag = "R5"; wr(0, 2048, 8'h33, 1); wr(1, 2048, 8'h00, 4); rd(0, 12, 1); wr(0, 2048, 8'h77, 2); rd(0, 12, 1);
    tag = "R7"; wr(0, 2049, 8'hCE, 1); wr(0, 5, 8'h01, 1); rd(0, 12, 1); rd(0, 13, 1);
    tag = "R2"; wr(0, 0, 0, 1); rd(0, 12, 1);
    tag = "R9"; wr(1, 0, 1, 1); dump(1, 26); wr(1, 132, 8'h11, 2); idle(); rd(1, 12, 1); idle();
    wr(1, 132, 8'h22, 1); idle(); idle(); rd(1, 30, 1); rd(1, 0, 1);
    tag = "R6"; wr(0, 0, 2, 1); dump(0, 28); wr(0, 2050, 8'hFA, 1); wr(0, 2050, 8'hFB, 1);
    wr(0, 2050, 8'hFA, 2); rd(0, 12, 1); wr(0, 2050, 8'hFA, 1); rd(0, 12, 1);
    tag = "R4"; wr(1, 0, 2, 1); rd(1, 4, 1); rd(1, 5, 1); wr(0, 133, 8'hFA, 1); wr(1, 2053, 8'hFA, 1); rd(1, 12, 1);
    dump(1, 28); wr(1, 0, 0, 1); dump(1, 28); wr(0, 0, 1, 1); rd(0, 4, 1); rd(0, 5, 1);
    tag = "R10"; wr(0, 2049, 1, 1); rd(0, 12, 1); idle(); idle(); rd(0, 8, 1); idle();
    tag = "R2"; wr(0, 0, 3, 1); rd(0, 0, 1); wr(1, 0, 8'hFF, 1); rd(1, 12, 1); idle();
    tag = "R1"; rst_n = 0; @(negedge clk); rst_n = 1; idle(); rd(0, 0, 1); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule